// File: doc/BRIEF.md
# MESI Snooping Cache Line Controller

This block keeps the coherence state of every line of a small direct-mapped, write-back cache that shares a snooping bus with other caches. Each line is in one of four states: Invalid, Shared, Exclusive or Modified. Each cycle the block can take one local processor access (read or write) and one snooped transaction seen on the bus from another cache. It updates the line states and reports hit or miss to the processor. It also raises the bus transactions that the access needs: a memory read, a read-with-intent-to-modify (RWITM), or an invalidate. It raises copy-back requests for dirty data, both for eviction and for snoops.

The controller has two copy-back outputs. One is for a Modified victim that a local fill evicts. The other is for a Modified line that a snoop hits. Both can occur in the same cycle on different lines. The block drives a shared output while it holds a valid copy of an address that another cache is reading. The other caches combine this output as a wired-OR. The block samples its own shared input in the same cycle as a local read miss, and uses it to choose the fill state.

All outputs are registered, so every response appears on the clock edge after the request. A snoop and a local access in the same cycle are allowed. If both target the same line index, the snoop takes effect first, and the local access is then decided on the state the snoop left behind.

Top module: `mesi_line_ctrl`

## Requirements
- R1: After reset every line is Invalid. During reset all outputs are 0. The first access to any address after reset misses, and no copy-back is requested.
- R2: A local read miss issues a memory read (bus_op_o = 0) for the requested address. The line is filled as Shared if bus_shared_i was 1 in the request cycle, and as Exclusive otherwise.
- R3: A local read that hits a Shared, Exclusive or Modified line reports a hit, issues no bus transaction and leaves the state unchanged.
- R4: A local write miss issues RWITM (bus_op_o = 1) for the requested address, reports a miss and leaves the line Modified.
- R5: A local write to a Shared line reports a hit, issues an invalidate (bus_op_o = 2) for that address and leaves the line Modified.
- R6: A local write that hits an Exclusive or Modified line reports a hit, issues no bus transaction and leaves the line Modified.
- R7: A snooped read (snp_op_i = 0) that hits a valid line raises snp_shared_o. If the line was Modified, the block also requests a snoop copy-back of that address. Modified and Exclusive lines become Shared, and Shared lines stay Shared.
- R8: A snooped RWITM (snp_op_i = 1) or invalidate (snp_op_i = 2) that hits a valid line makes the line Invalid. The block requests a snoop copy-back only if the line was Modified, and does not raise snp_shared_o.
- R9: A local miss whose victim line (same index, other tag) is Modified requests an eviction copy-back carrying the victim's address. A victim in any other state is dropped with no copy-back.
- R10: When a snoop and a local access in the same cycle target the same index, the snoop transition is applied first. The local access is then decided against the resulting state.
- R11: A snoop that misses (tag differs or line Invalid), and snp_op_i = 3, has no effect on any line and raises neither snp_shared_o nor a snoop copy-back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req_i | input | 1 | Local access valid this cycle |
| cpu_we_i | input | 1 | Local access is a write |
| cpu_addr_i | input | ADDR_W | Local line address (tag above index) |
| snp_valid_i | input | 1 | Snooped transaction valid this cycle |
| snp_op_i | input | 2 | Snooped kind: 0 read, 1 RWITM, 2 invalidate, 3 none |
| snp_addr_i | input | ADDR_W | Snooped line address |
| bus_shared_i | input | 1 | Wired-OR shared signal from other caches |
| cpu_resp_o | output | 1 | Response to the local access of the previous cycle |
| cpu_hit_o | output | 1 | That access hit |
| bus_valid_o | output | 1 | Bus transaction requested |
| bus_op_o | output | 2 | 0 memory read, 1 RWITM, 2 invalidate |
| bus_addr_o | output | ADDR_W | Address of the bus transaction |
| evict_wb_o | output | 1 | Copy-back of an evicted Modified line |
| evict_addr_o | output | ADDR_W | Address of the evicted line |
| snp_shared_o | output | 1 | This cache holds the snooped read's line |
| snp_wb_o | output | 1 | Copy-back forced by a snoop |
| snp_wb_addr_o | output | ADDR_W | Address of the snoop copy-back |

## Verification
Some rules are checked on every cycle by the assertions. The bus operation must agree with the hit flag and with the kind of access. Snoop responses and copy-backs may appear only after a snoop of the right kind. An eviction copy-back may occur only together with a miss fill. All states must be Invalid when reset ends. Other behaviour depends on a history of accesses and only the bench's scenarios can show it. These scenarios cover the choice between Shared and Exclusive on a fill, the silent Exclusive-to-Modified upgrade, and the victim's address on eviction. They also cover the order when a snoop and a local access hit the same line in one cycle, which the bench shows through the state left behind.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
  // line coherence states
  localparam logic [1:0] ST_I = 2'd0;
  localparam logic [1:0] ST_S = 2'd1;
  localparam logic [1:0] ST_E = 2'd2;
  localparam logic [1:0] ST_M = 2'd3;

  // outgoing bus transaction kinds
  localparam logic [1:0] BUS_RD    = 2'd0;
  localparam logic [1:0] BUS_RWITM = 2'd1;
  localparam logic [1:0] BUS_INV   = 2'd2;

  // snooped transaction kinds
  localparam logic [1:0] SNP_RD    = 2'd0;
  localparam logic [1:0] SNP_RWITM = 2'd1;
  localparam logic [1:0] SNP_INV   = 2'd2;
endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store #(
  parameter int IDX_W = 3,
  parameter int TAG_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] s_idx_i,
  output logic [TAG_W-1:0] s_tag_o,
  output logic [1:0]       s_st_o,
  input  logic             s_we_i,
  input  logic [1:0]       s_st_i,
  input  logic [IDX_W-1:0] l_idx_i,
  output logic [TAG_W-1:0] l_tag_o,
  output logic [1:0]       l_st_o,
  input  logic             l_we_i,
  input  logic [1:0]       l_st_i,
  input  logic             l_tag_we_i,
  input  logic [TAG_W-1:0] l_tag_i
);
  import mesi_pkg::*;
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0][1:0] st_q;
  logic [TAG_W-1:0]      tag_mem [LINES];

  assign s_tag_o = tag_mem[s_idx_i];
  assign s_st_o  = st_q[s_idx_i];
  assign l_tag_o = tag_mem[l_idx_i];
  assign l_st_o  = st_q[l_idx_i];

  // tag memory: no reset, single write port
  always_ff @(posedge clk) begin
    if (l_tag_we_i) tag_mem[l_idx_i] <= l_tag_i;
  end

  // state bits: local write lands after the snoop write, so it wins on a shared index
  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= '0;
    end else begin
      if (s_we_i) st_q[s_idx_i] <= s_st_i;
      if (l_we_i) st_q[l_idx_i] <= l_st_i;
    end
  end

  // R1
  all_invalid_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (st_q == '0));
endmodule

// File: rtl/mesi_snoop_fsm.sv
module mesi_snoop_fsm (
  input  logic       valid_i,
  input  logic [1:0] op_i,
  input  logic [1:0] st_i,
  input  logic       tag_eq_i,
  output logic       wr_o,
  output logic [1:0] nxt_o,
  output logic       wb_o,
  output logic       shared_o
);
  import mesi_pkg::*;
  logic present;
  assign present = valid_i && tag_eq_i && (st_i != ST_I);

  always_comb begin
    wr_o     = 1'b0;
    nxt_o    = st_i;
    wb_o     = 1'b0;
    shared_o = 1'b0;
    if (present) begin
      unique case (op_i)
        SNP_RD: begin
          shared_o = 1'b1;
          wr_o     = 1'b1;
          nxt_o    = ST_S;
          wb_o     = (st_i == ST_M);
        end
        SNP_RWITM, SNP_INV: begin
          wr_o  = 1'b1;
          nxt_o = ST_I;
          wb_o  = (st_i == ST_M);
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/mesi_local_fsm.sv
module mesi_local_fsm (
  input  logic       req_i,
  input  logic       we_i,
  input  logic [1:0] st_i,
  input  logic       tag_eq_i,
  input  logic       shared_i,
  output logic       wr_o,
  output logic       tag_wr_o,
  output logic [1:0] nxt_o,
  output logic       hit_o,
  output logic       bus_v_o,
  output logic [1:0] bus_op_o,
  output logic       evict_o
);
  import mesi_pkg::*;
  logic hit;
  assign hit = tag_eq_i && (st_i != ST_I);

  always_comb begin
    wr_o     = 1'b0;
    tag_wr_o = 1'b0;
    nxt_o    = st_i;
    hit_o    = 1'b0;
    bus_v_o  = 1'b0;
    bus_op_o = BUS_RD;
    evict_o  = 1'b0;
    if (req_i) begin
      hit_o = hit;
      if (hit) begin
        if (we_i) begin
          wr_o  = 1'b1;
          nxt_o = ST_M;
          if (st_i == ST_S) begin
            bus_v_o  = 1'b1;
            bus_op_o = BUS_INV;
          end
        end
      end else begin
        wr_o     = 1'b1;
        tag_wr_o = 1'b1;
        bus_v_o  = 1'b1;
        evict_o  = (st_i == ST_M);
        if (we_i) begin
          bus_op_o = BUS_RWITM;
          nxt_o    = ST_M;
        end else begin
          bus_op_o = BUS_RD;
          nxt_o    = shared_i ? ST_S : ST_E;
        end
      end
    end
  end
endmodule

// File: rtl/mesi_line_ctrl.sv
module mesi_line_ctrl #(
  parameter int ADDR_W = 12,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic              snp_valid_i,
  input  logic [1:0]        snp_op_i,
  input  logic [ADDR_W-1:0] snp_addr_i,
  input  logic              bus_shared_i,
  output logic              cpu_resp_o,
  output logic              cpu_hit_o,
  output logic              bus_valid_o,
  output logic [1:0]        bus_op_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              evict_wb_o,
  output logic [ADDR_W-1:0] evict_addr_o,
  output logic              snp_shared_o,
  output logic              snp_wb_o,
  output logic [ADDR_W-1:0] snp_wb_addr_o
);
  import mesi_pkg::*;
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0] s_idx, l_idx;
  logic [TAG_W-1:0] s_tag, l_tag, s_tag_rd, l_tag_rd;
  logic [1:0]       s_st_rd, l_st_rd, l_st_eff;
  logic             s_wr, s_wb, s_sh;
  logic [1:0]       s_nxt;
  logic             l_wr, l_tag_wr, l_hit, l_bus_v, l_evict;
  logic [1:0]       l_nxt, l_bus_op;
  logic             same_line;

  assign s_idx = snp_addr_i[IDX_W-1:0];
  assign s_tag = snp_addr_i[ADDR_W-1:IDX_W];
  assign l_idx = cpu_addr_i[IDX_W-1:0];
  assign l_tag = cpu_addr_i[ADDR_W-1:IDX_W];

  mesi_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rst(rst),
    .s_idx_i(s_idx), .s_tag_o(s_tag_rd), .s_st_o(s_st_rd),
    .s_we_i(s_wr), .s_st_i(s_nxt),
    .l_idx_i(l_idx), .l_tag_o(l_tag_rd), .l_st_o(l_st_rd),
    .l_we_i(l_wr), .l_st_i(l_nxt),
    .l_tag_we_i(l_tag_wr), .l_tag_i(l_tag)
  );

  mesi_snoop_fsm u_snoop (
    .valid_i(snp_valid_i), .op_i(snp_op_i), .st_i(s_st_rd),
    .tag_eq_i(s_tag_rd == s_tag),
    .wr_o(s_wr), .nxt_o(s_nxt), .wb_o(s_wb), .shared_o(s_sh)
  );

  // snoop result forwarded to a local access on the same index
  assign same_line = s_wr && (s_idx == l_idx);
  assign l_st_eff  = same_line ? s_nxt : l_st_rd;

  mesi_local_fsm u_local (
    .req_i(cpu_req_i), .we_i(cpu_we_i), .st_i(l_st_eff),
    .tag_eq_i(l_tag_rd == l_tag), .shared_i(bus_shared_i),
    .wr_o(l_wr), .tag_wr_o(l_tag_wr), .nxt_o(l_nxt), .hit_o(l_hit),
    .bus_v_o(l_bus_v), .bus_op_o(l_bus_op), .evict_o(l_evict)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_resp_o    <= 1'b0;
      cpu_hit_o     <= 1'b0;
      bus_valid_o   <= 1'b0;
      bus_op_o      <= BUS_RD;
      bus_addr_o    <= '0;
      evict_wb_o    <= 1'b0;
      evict_addr_o  <= '0;
      snp_shared_o  <= 1'b0;
      snp_wb_o      <= 1'b0;
      snp_wb_addr_o <= '0;
    end else begin
      cpu_resp_o    <= cpu_req_i;
      cpu_hit_o     <= l_hit;
      bus_valid_o   <= l_bus_v;
      bus_op_o      <= l_bus_op;
      bus_addr_o    <= cpu_addr_i;
      evict_wb_o    <= l_evict;
      evict_addr_o  <= {l_tag_rd, l_idx};
      snp_shared_o  <= s_sh;
      snp_wb_o      <= s_wb;
      snp_wb_addr_o <= snp_addr_i;
    end
  end

  // R2
  rd_miss_op_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid_o && bus_op_o == BUS_RD) |-> (cpu_resp_o && !cpu_hit_o && !$past(cpu_we_i)));
  // R3
  rd_hit_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_resp_o && cpu_hit_o && !$past(cpu_we_i)) |-> !bus_valid_o);
  // R4
  wr_miss_op_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid_o && bus_op_o == BUS_RWITM) |-> (cpu_resp_o && !cpu_hit_o && $past(cpu_we_i)));
  // R5
  inv_on_hit_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_valid_o && bus_op_o == BUS_INV) |-> (cpu_resp_o && cpu_hit_o && $past(cpu_we_i)));
  // R6
  wr_hit_op_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_resp_o && cpu_hit_o && $past(cpu_we_i) && bus_valid_o) |-> (bus_op_o == BUS_INV));
  // R7
  shared_on_read_chk: assert property (@(posedge clk) disable iff (rst)
    snp_shared_o |-> ($past(snp_valid_i) && $past(snp_op_i) == SNP_RD));
  // R8
  snoop_wb_cause_chk: assert property (@(posedge clk) disable iff (rst)
    snp_wb_o |-> ($past(snp_valid_i) && $past(snp_op_i) != 2'd3));
  // R9
  evict_with_fill_chk: assert property (@(posedge clk) disable iff (rst)
    evict_wb_o |-> (bus_valid_o && bus_op_o != BUS_INV && !cpu_hit_o));
endmodule

// File: tb/mesi_line_ctrl_tb.sv
module mesi_line_ctrl_tb;
  localparam int AW = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_req, cpu_we, snp_valid, bus_shared;
  logic [1:0] snp_op;
  logic [AW-1:0] cpu_addr, snp_addr;
  logic cpu_resp, cpu_hit, bus_valid, evict_wb, snp_shared, snp_wb;
  logic [1:0] bus_op;
  logic [AW-1:0] bus_addr, evict_addr, snp_wb_addr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  mesi_line_ctrl #(.ADDR_W(AW), .IDX_W(3)) u_dut (
    .clk(clk), .rst(rst),
    .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr),
    .snp_valid_i(snp_valid), .snp_op_i(snp_op), .snp_addr_i(snp_addr),
    .bus_shared_i(bus_shared),
    .cpu_resp_o(cpu_resp), .cpu_hit_o(cpu_hit),
    .bus_valid_o(bus_valid), .bus_op_o(bus_op), .bus_addr_o(bus_addr),
    .evict_wb_o(evict_wb), .evict_addr_o(evict_addr),
    .snp_shared_o(snp_shared), .snp_wb_o(snp_wb), .snp_wb_addr_o(snp_wb_addr)
  );

  typedef struct packed {
    logic [3:0]    rq;
    logic          req;
    logic          we;
    logic [AW-1:0] addr;
    logic          sv;
    logic [1:0]    sop;
    logic [AW-1:0] saddr;
    logic          shin;
    logic          e_resp;
    logic          e_hit;
    logic          e_bv;
    logic [1:0]    e_bop;
    logic [AW-1:0] e_baddr;
    logic          e_ev;
    logic [AW-1:0] e_eaddr;
    logic          e_sh;
    logic          e_swb;
    logic [AW-1:0] e_swbaddr;
  } vec_t;

  // lines: LA,LB index 0 (tags 1,2); LC index 1; LD index 2; LE index 3
  localparam logic [AW-1:0] LA = 12'h008, LB = 12'h010, LC = 12'h009,
                            LD = 12'h00A, LE = 12'h00B, LZ = 12'h000;
  localparam int NV = 23;
  localparam vec_t VECS [NV] = '{
    // R1/R2: first read misses, no sharer -> Exclusive
    '{4'd1, 1'b1,1'b0,LA, 1'b0,2'd0,LZ, 1'b0, 1'b1,1'b0,1'b1,2'd0,LA, 1'b0,LZ, 1'b0,1'b0,LZ},
    // R3: read hit, quiet
    '{4'd3, 1'b1,1'b0,LA, 1'b0,2'd0,LZ, 1'b0, 1'b1,1'b1,1'b0,2'd0,LZ, 1'b0,LZ, 1'b0,1'b0,LZ},
    // R6: write hit on Exclusive, silent upgrade
    '{4'd6, 1'b1,1'b1,LA, 1'b0,2'd0,LZ, 1'b0, 1'b1,1'b1,1'b0,2'd0,LZ, 1'b0,LZ, 1'b0,1'b0,LZ},
    // R7: snoop read on Modified -> copy-back, Shared
    '{4'd7, 1'b0,1'b0,LZ, 1'b1,2'd0,LA, 1'b0, 1'b0,1'b0,1'b0,2'd0,LZ, 1'b0,LZ, 1'b1,1'b1,LA},
    // R5: write to Shared -> invalidate
    '{4'd5, 1'b1,1'b1,LA, 1'b0,2'd0,LZ, 1'b0, 1'b1,1'b1,1'b1,2'd2,LA, 1'b0,LZ, 1'b0,1'b0,LZ},
    // R9: conflict read evicts Modified LA; sharer present -> Shared
    '{4'd9, 1'b1,1'b0,LB, 1'b0,2'd0,LZ, 1'b1, 1'b1,1'b0,1'b1,2'd0,LB, 1'b1,LA, 1'b0,1'b0,LZ},
    // R8: snoop RWITM on Shared -> Invalid, no copy-back
    '{4'd8, 1'b0,1'b0,LZ, 1'b1,2'd1,LB, 1'b0, 1'b0,1'b0,1'b0,2'd0,LZ, 1'b0,LZ, 1'b0,1'b0,LZ},
    // R9: reread LB misses, Invalid victim silent
    '{4'd9, 1'b1,1'b0,LB, 1'b0,2'd0,LZ, 1'b0, 1'b1,1'b0,1'b1,2'd0,LB, 1'b0,LZ, 1'b0,1'b0,LZ},
    // R9: Exclusive victim LB dropped silently, LA filled Exclusive
    '{4'd9, 1'b1,1'b0,LA, 1'b0,2'd0,LZ, 1'b0, 1'b1,1'b0,1'b1,2'd0,LA, 1'b0,LZ, 1'b0,1'b0,LZ},
    // R2/R6: LA Exclusive -> write with no traffic
    '{4'd2, 1'b1,1'b1,LA, 1'b0,2'd0,LZ, 1'b0, 1'b1,1'b1,1'b0,2'd0,LZ, 1'b0,LZ, 1'b0,1'b0,LZ},
    // R4: write miss -> RWITM
    '{4'd4, 1'b1,1'b1,LC, 1'b0,2'd0,LZ, 1'b0, 1'b1,1'b0,1'b1,2'd1,LC, 1'b0,LZ, 1'b0,1'b0,LZ},
    // R8: snoop invalidate on Modified -> copy-back
    '{4'd8, 1'b0,1'b0,LZ, 1'b1,2'd2,LC, 1'b0, 1'b0,1'b0,1'b0,2'd0,LZ, 1'b0,LZ, 1'b0,1'b1,LC},
    // R11: snoop of a line not held
    '{4'd11,1'b0,1'b0,LZ, 1'b1,2'd0,LD, 1'b0, 1'b0,1'b0,1'b0,2'd0,LZ, 1'b0,LZ, 1'b0,1'b0,LZ},
    // R2: read miss with sharer -> Shared
    '{4'd2, 1'b1,1'b0,LC, 1'b0,2'd0,LZ, 1'b1, 1'b1,0,1'b1,2'd0,LC, 1'b0,LZ, 1'b0,1'b0,LZ},
    // R10: snoop RWITM + local read same line: line invalid first -> miss, Exclusive
    '{4'd10,1'b1,1'b0,LC, 1'b1,2'd1,LC, 1'b0, 1'b1,1'b0,1'b1,2'd0,LC, 1'b0,LZ, 1'b0,1'b0,LZ},
    // R10: snoop read + local write: E->S first, then write hits Shared -> invalidate
    '{4'd10,1'b1,1'b1,LC, 1'b1,2'd0,LC, 1'b0, 1'b1,1'b1,1'b1,2'd2,LC, 1'b0,LZ, 1'b1,1'b0,LZ},
    // R7: LC Modified -> copy-back on snoop read
    '{4'd7, 1'b0,1'b0,LZ, 1'b1,2'd0,LC, 1'b0, 1'b0,1'b0,1'b0,2'd0,LZ, 1'b0,LZ, 1'b1,1'b1,LC},
    // R4: write miss LD while snoop read of Shared LC on other index
    '{4'd4, 1'b1,1'b1,LD, 1'b1,2'd0,LC, 1'b0, 1'b1,1'b0,1'b1,2'd1,LD, 1'b0,LZ, 1'b1,1'b0,LZ},
    // R6: write hit on Modified stays quiet
    '{4'd6, 1'b1,1'b1,LD, 1'b0,2'd0,LZ, 1'b0, 1'b1,1'b1,1'b0,2'd0,LZ, 1'b0,LZ, 1'b0,1'b0,LZ},
    // R2: read miss LE with sharer -> Shared
    '{4'd2, 1'b1,1'b0,LE, 1'b0,2'd0,LZ, 1'b1, 1'b1,1'b0,1'b1,2'd0,LE, 1'b0,LZ, 1'b0,1'b0,LZ},
    // R7: snoop read on Shared: shared, no copy-back
    '{4'd7, 1'b0,1'b0,LZ, 1'b1,2'd0,LE, 1'b0, 1'b0,1'b0,1'b0,2'd0,LZ, 1'b0,LZ, 1'b1,1'b0,LZ},
    // R5: LE still Shared -> invalidate on write
    '{4'd5, 1'b1,1'b1,LE, 1'b0,2'd0,LZ, 1'b0, 1'b1,1'b1,1'b1,2'd2,LE, 1'b0,LZ, 1'b0,1'b0,LZ},
    // R9: LB read evicts Modified LA with LA's address
    '{4'd9, 1'b1,1'b0,LB, 1'b0,2'd0,LZ, 1'b0, 1'b1,1'b0,1'b1,2'd0,LB, 1'b1,LA, 1'b0,1'b0,LZ}
  };

  task automatic drive_idle();
    cpu_req = 1'b0; cpu_we = 1'b0; cpu_addr = '0;
    snp_valid = 1'b0; snp_op = 2'd0; snp_addr = '0; bus_shared = 1'b0;
  endtask

  task automatic check_vec(input vec_t v);
    logic bad;
    bad = (cpu_resp != v.e_resp) || (cpu_hit != v.e_hit) || (bus_valid != v.e_bv) ||
          (evict_wb != v.e_ev) || (snp_shared != v.e_sh) || (snp_wb != v.e_swb) ||
          (v.e_bv && (bus_op != v.e_bop || bus_addr != v.e_baddr)) ||
          (v.e_ev && evict_addr != v.e_eaddr) ||
          (v.e_swb && snp_wb_addr != v.e_swbaddr);
    checks++;
    if (bad) begin
      errors++;
      $display("FAIL R%0d got resp=%b hit=%b bv=%b op=%0d ba=%h ev=%b ea=%h sh=%b swb=%b sa=%h exp resp=%b hit=%b bv=%b op=%0d ba=%h ev=%b ea=%h sh=%b swb=%b sa=%h",
        v.rq, cpu_resp, cpu_hit, bus_valid, bus_op, bus_addr, evict_wb, evict_addr,
        snp_shared, snp_wb, snp_wb_addr, v.e_resp, v.e_hit, v.e_bv, v.e_bop, v.e_baddr,
        v.e_ev, v.e_eaddr, v.e_sh, v.e_swb, v.e_swbaddr);
    end
  endtask

  task automatic check_reset_outputs();
    checks++;
    if ({cpu_resp, cpu_hit, bus_valid, evict_wb, snp_shared, snp_wb} != 6'b0) begin
      errors++;
      $display("FAIL R1 reset outputs got %b expected 000000",
        {cpu_resp, cpu_hit, bus_valid, evict_wb, snp_shared, snp_wb});
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 5000) begin
        errors++;
        $display("FAIL watchdog expired got %0d cycles expected under 5000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    vec_t dv;
    drive_idle();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check_reset_outputs();  // R1
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      cpu_req = VECS[i].req; cpu_we = VECS[i].we; cpu_addr = VECS[i].addr;
      snp_valid = VECS[i].sv; snp_op = VECS[i].sop; snp_addr = VECS[i].saddr;
      bus_shared = VECS[i].shin;
      @(negedge clk);
      check_vec(VECS[i]);
    end

    // R11: snoop kind 3 on a held Modified line (LD) has no effect
    drive_idle();
    snp_valid = 1'b1; snp_op = 2'd3; snp_addr = LD;
    @(negedge clk);
    dv = '{4'd11, 1'b0,1'b0,LZ, 1'b1,2'd3,LD, 1'b0, 1'b0,1'b0,1'b0,2'd0,LZ, 1'b0,LZ, 1'b0,1'b0,LZ};
    check_vec(dv);
    drive_idle();
    cpu_req = 1'b1; cpu_we = 1'b1; cpu_addr = LD;
    @(negedge clk);
    dv = '{4'd11, 1'b1,1'b1,LD, 1'b0,2'd0,LZ, 1'b0, 1'b1,1'b1,1'b0,2'd0,LZ, 1'b0,LZ, 1'b0,1'b0,LZ};
    check_vec(dv);

    // R1: reset mid-run clears dirty LD; outputs quiet during reset
    drive_idle();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check_reset_outputs();
    rst = 1'b0;
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = LD;
    @(negedge clk);
    dv = '{4'd1, 1'b1,1'b0,LD, 1'b0,2'd0,LZ, 1'b0, 1'b1,1'b0,1'b1,2'd0,LD, 1'b0,LZ, 1'b0,1'b0,LZ};
    check_vec(dv);
    drive_idle();
    @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule